// File: doc/BRIEF.md
# Core image loader with register clearing

This block launches a processing core. On an accepted start request it copies a 512-word image from a shared memory into the core's register RAM, one forced long read at a time. Word n comes from the shared-memory byte address start_addr + 4n and is written to register RAM address n. Writes go in ascending order, and each write waits for the shared memory to acknowledge its read. The top 16 register locations shadow the core's I/O registers. Those reads are still issued, but zero is written in place of the returned data. When the last word lands, the load counter wraps to 0 and the core runs from address 0 with no extra cycle in between.

The block also holds the core's four output-type I/O registers: output direction, two counter controls and video configuration. These clear asynchronously whenever the active-low core reset is held low. The core can write them only while it runs. A read-only parameter register is captured from the start request. Launching never clears it.

The controller has three states. `ST_IDLE` waits for a start. `ST_LOAD` issues reads and writes the image. `ST_RUN` marks the core as executing. The transitions are:
- ST_IDLE -> ST_LOAD on a start request.
- ST_LOAD -> ST_LOAD on an acknowledge for any word but the last, and while no acknowledge arrives.
- ST_LOAD -> ST_RUN on the acknowledge of word 511.
- ST_RUN -> ST_LOAD on a new start request (relaunch).
- Any state -> ST_IDLE asynchronously while reset is low.

Top module: `core_image_loader`

## Requirements
- R1: After an accepted start, exactly 512 register RAM writes occur, to addresses 0,1,...,511 in that order. A write occurs only in a cycle where mem_ack is high during loading.
- R2: During loading, mem_req stays high. The read for word n presents mem_addr = start_addr + 4n, taken modulo 2^ADDR_W.
- R3: Addresses 0 through 495 receive the mem_rdata value returned with the acknowledge for that word.
- R4: Addresses 496 through 511 (0x1F0 to 0x1FF) receive zero, although their reads are still issued and acknowledged.
- R5: run is low throughout loading and is high in the cycle after the write to address 511. At that point pc is 0. During loading, pc equals the address of the word being loaded.
- R6: A start request while loading is ignored: neither the base address nor the parameter changes. A start request in idle or in run is accepted.
- R7: While rst_n is low, dir_q, ctra_q, ctrb_q and vcfg_q are 0 immediately, without a clock edge. In the same condition, run, mem_req and ram_we are 0 and pc is 0.
- R8: io_we writes io_wdata into the register chosen by io_sel (0 = direction, 1 = counter A, 2 = counter B, 3 = video configuration) only while run is high. io_we has no effect while loading or idle.
- R9: par_q takes start_param on an accepted start and holds it through loading and running. The zero fill does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset; low means the core is inactive |
| start_req | input | 1 | Start (launch) request |
| start_addr | input | ADDR_W | Shared-memory byte address of image word 0 |
| start_param | input | DATA_W | Value for the read-only parameter register |
| mem_req | output | 1 | Shared-memory read request |
| mem_addr | output | ADDR_W | Shared-memory read byte address |
| mem_ack | input | 1 | Read acknowledge; mem_rdata is valid with it |
| mem_rdata | input | DATA_W | Read data |
| ram_we | output | 1 | Register RAM write enable |
| ram_waddr | output | 9 | Register RAM write address |
| ram_wdata | output | DATA_W | Register RAM write data |
| run | output | 1 | Core executing |
| pc | output | 9 | Load counter / starting program counter |
| par_q | output | DATA_W | Read-only parameter register |
| io_we | input | 1 | I/O register write strobe from the core |
| io_sel | input | 2 | I/O register select |
| io_wdata | input | DATA_W | I/O register write data |
| dir_q | output | DATA_W | Output-direction register |
| ctra_q | output | DATA_W | Counter A control register |
| ctrb_q | output | DATA_W | Counter B control register |
| vcfg_q | output | DATA_W | Video configuration register |

## Verification
The bench launches from several bases with acknowledge latencies of zero, one and two cycles. One base sits near the top of the address space, so that a design which truncates or fails to wrap the address sum fetches the wrong words. The bench checks the seam between fetched data and the zero fill at 495/496. A design that is off by one there, or that skips the zero-fill reads, leaves a wrong value or a short write count. A stray start is injected mid-load, which catches a design that restarts or rebases. The bench watches the exact cycle run rises with pc at 0, catching an idle step or a missed wrap. Reset is dropped between clock edges, so synchronous clearing of the I/O registers shows as stale values.

// File: rtl/loader_pkg.sv
package loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } ld_state_e;

    localparam int unsigned IO_REG_COUNT = 4;
    localparam int unsigned IO_DIR  = 0;
    localparam int unsigned IO_CTRA = 1;
    localparam int unsigned IO_CTRB = 2;
    localparam int unsigned IO_VCFG = 3;
endpackage

// File: rtl/loader_fsm.sv
module loader_fsm
    import loader_pkg::*;
#(
    parameter int unsigned DEPTH    = 512,
    parameter int unsigned ZERO_TOP = 16,
    localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             mem_ack,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             loading,
    output logic             write,
    output logic             zero_fill,
    output logic             run
);
    localparam int unsigned ZERO_BASE = DEPTH - ZERO_TOP;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    ld_state_e        state, state_nx;
    logic [IDX_W-1:0] cnt_nx;
    logic             last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start_req) begin
                    state_nx = ST_LOAD;
                    cnt_nx   = '0;
                end
            end
            ST_LOAD: begin
                if (mem_ack) begin
                    if (last) begin
                        state_nx = ST_RUN;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = idx + IDX_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (start_req) begin
                    state_nx = ST_LOAD;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        loading   = (state == ST_LOAD);
        run       = (state == ST_RUN);
        accept    = start_req && (state != ST_LOAD);
        write     = loading && mem_ack;
        last      = (idx == LAST_IDX);
        zero_fill = (int'(idx) >= int'(ZERO_BASE));
    end

    // R5: the final write hands over to run with the counter wrapped to 0
    a_r5_wrap_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (write && last) |=> (run && idx == '0));

    // R6: with no acknowledge, loading holds its place whatever start does
    a_r6_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && !mem_ack) |=> (loading && $stable(idx)));
endmodule

// File: rtl/loader_addr.sv
module loader_addr #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned WORD_SHIFT = 2;

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= '0;
        else if (accept)
            base_q <= start_addr;
    end

    assign mem_addr = base_q + (ADDR_W'(idx) << WORD_SHIFT);

    // R6: the base only moves on an accepted start
    a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(base_q));
endmodule

// File: rtl/io_out_regs.sv
module io_out_regs
    import loader_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SEL_W = $clog2(IO_REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [IO_REG_COUNT-1:0][DATA_W-1:0] q
);
    for (genvar g = 0; g < IO_REG_COUNT; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[g] <= '0;
            else if (wr_en && sel == SEL_W'(g))
                q[g] <= wdata;
        end
    end
endmodule

// File: rtl/core_image_loader.sv
module core_image_loader
    import loader_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned DEPTH    = 512,
    parameter int unsigned ZERO_TOP = 16,
    localparam int unsigned IDX_W   = $clog2(DEPTH),
    localparam int unsigned SEL_W   = $clog2(IO_REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_param,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              run,
    output logic [IDX_W-1:0]  pc,
    output logic [DATA_W-1:0] par_q,
    input  logic              io_we,
    input  logic [SEL_W-1:0]  io_sel,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] ctra_q,
    output logic [DATA_W-1:0] ctrb_q,
    output logic [DATA_W-1:0] vcfg_q
);
    localparam int unsigned ZERO_BASE = DEPTH - ZERO_TOP;

    logic [IDX_W-1:0] idx;
    logic             accept, loading, write, zero_fill;
    logic [IO_REG_COUNT-1:0][DATA_W-1:0] io_q;

    loader_fsm #(.DEPTH(DEPTH), .ZERO_TOP(ZERO_TOP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .mem_ack(mem_ack),
        .idx(idx), .accept(accept), .loading(loading), .write(write),
        .zero_fill(zero_fill), .run(run)
    );

    loader_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .start_addr(start_addr),
        .idx(idx), .mem_addr(mem_addr)
    );

    io_out_regs #(.DATA_W(DATA_W)) u_io (
        .clk(clk), .rst_n(rst_n), .wr_en(io_we && run), .sel(io_sel),
        .wdata(io_wdata), .q(io_q)
    );

    // read-only parameter register: untouched by the image load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            par_q <= '0;
        else if (accept)
            par_q <= start_param;
    end

    always_comb begin
        mem_req   = loading;
        ram_we    = write;
        ram_waddr = idx;
        ram_wdata = zero_fill ? '0 : mem_rdata;
        pc        = idx;
        dir_q     = io_q[IO_DIR];
        ctra_q    = io_q[IO_CTRA];
        ctrb_q    = io_q[IO_CTRB];
        vcfg_q    = io_q[IO_VCFG];
    end

    // R4: the I/O shadow range is always written with zero
    a_r4_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && int'(ram_waddr) >= int'(ZERO_BASE)) |-> (ram_wdata == '0));

    // R5: no shared-memory read while the core runs
    a_r5_run_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !mem_req);

    // R1: consecutive writes step the address by one
    a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && int'(ram_waddr) < int'(DEPTH - 1)) |=> (ram_waddr == $past(ram_waddr) + IDX_W'(1)));

    // R8: I/O registers hold while the core is not running
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(dir_q) && $stable(ctra_q) && $stable(ctrb_q) && $stable(vcfg_q)));

    // R9: parameter held while loading
    a_r9_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && $past(loading)) |-> $stable(par_q));
endmodule

// File: tb/tb_core_image_loader.sv
module tb_core_image_loader;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 512;
    localparam int ZBASE = 496;

    typedef struct packed {
        logic [15:0] base;
        logic [3:0]  lat;
        logic        poke;
        logic [31:0] par;
    } vec_t;

    localparam vec_t VEC [3] = '{
        '{16'h0000, 4'd0, 1'b0, 32'h1111_0001},
        '{16'h1230, 4'd2, 1'b1, 32'h2222_0002},
        '{16'hFF00, 4'd1, 1'b0, 32'h3333_0003}
    };

    logic clk = 0, rst_n = 0, start_req = 0, mem_ack = 0, io_we = 0;
    logic [15:0] start_addr = '0;
    logic [31:0] start_param = '0, mem_rdata = '0, io_wdata = '0;
    logic [1:0]  io_sel = '0;
    logic mem_req, ram_we, run;
    logic [15:0] mem_addr;
    logic [8:0] ram_waddr, pc;
    logic [31:0] ram_wdata, par_q, dir_q, ctra_q, ctrb_q, vcfg_q;

    core_image_loader dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
        .start_param(start_param), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ram_we(ram_we),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .run(run), .pc(pc),
        .par_q(par_q), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
        .dir_q(dir_q), .ctra_q(ctra_q), .ctrb_q(ctrb_q), .vcfg_q(vcfg_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int lat = 0, waitc = 0;
    int wcount = 0;
    int pc_bad = 0, run_bad = 0, req_bad = 0;
    logic prev_last = 0, run_ok = 0, run_seen = 0;
    int   rec_addr [DEPTH];
    logic [31:0] rec_data [DEPTH];
    logic [15:0] rec_maddr [DEPTH];

    function automatic logic [31:0] mem_f(input logic [15:0] a);
        return {a, a ^ 16'hC3A5};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // shared-memory responder, driven on the falling edge
    always @(negedge clk) begin
        if (mem_req && waitc >= lat) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_f(mem_addr);
            waitc     <= 0;
        end else begin
            mem_ack <= 1'b0;
            waitc   <= mem_req ? waitc + 1 : 0;
        end
    end

    // monitor, sampled between falling and rising edge
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (prev_last && !run_seen) begin
                run_seen = 1;
                run_ok   = run && (pc == 9'd0);
            end
            prev_last = 0;
            if (wcount > 0 && wcount < DEPTH && run) run_bad++;
            if (wcount < DEPTH && !run_seen && (mem_req === 1'b0) && wcount > 0) req_bad++;
            if (ram_we) begin
                if (wcount < DEPTH) begin
                    if (pc != ram_waddr) pc_bad++;
                    rec_addr[wcount]  = int'(ram_waddr);
                    rec_data[wcount]  = ram_wdata;
                    rec_maddr[wcount] = mem_addr;
                end
                wcount++;
                prev_last = (ram_waddr == 9'd511);
            end
        end
    end

    task automatic launch(input vec_t v);
        int ord_bad = 0, ad_bad = 0, d_bad = 0, z_bad = 0;
        wcount = 0; pc_bad = 0; run_bad = 0; req_bad = 0;
        run_ok = 0; run_seen = 0; prev_last = 0;
        lat = int'(v.lat);
        @(negedge clk);
        start_req = 1; start_addr = v.base; start_param = v.par;
        @(negedge clk);
        start_req = 0;
        for (int i = 0; i < 3000 && !run_seen; i++) begin
            @(negedge clk);
            if (v.poke && wcount == 100) begin
                start_req = 1; start_addr = 16'hABC0; start_param = 32'hDEAD_BEEF;
                io_we = 1; io_sel = 2'd0; io_wdata = 32'hFFFF_FFFF;
            end else begin
                start_req = 0; io_we = 0;
            end
        end
        start_req = 0; io_we = 0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            if (rec_addr[k] != k) ord_bad++;
            if (rec_maddr[k] != 16'(v.base + 16'(k * 4))) ad_bad++;
            if (k < ZBASE && rec_data[k] != mem_f(16'(v.base + 16'(k * 4)))) d_bad++;
            if (k >= ZBASE && rec_data[k] != 32'd0) z_bad++;
        end
        check("R1 write count", 64'(wcount), 64'(DEPTH));
        check("R1 ascending order", 64'(ord_bad), 0);
        check(v.poke ? "R2/R6 read addresses despite stray start" : "R2 read addresses", 64'(ad_bad), 0);
        check("R2 req held during load", 64'(req_bad), 0);
        check("R3 fetched data", 64'(d_bad), 0);
        check("R4 zero fill", 64'(z_bad), 0);
        check("R5 run and pc 0 after last write", 64'(run_ok), 1);
        check("R5 run low while loading / pc tracks", 64'(run_bad + pc_bad), 0);
        check(v.poke ? "R6/R9 parameter kept" : "R9 parameter", 64'(par_q), 64'(v.par));
        if (v.poke) check("R8 io write ignored while loading", 64'(dir_q), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R7 reset run", 64'(run), 0);
        check("R7 reset req/we", 64'({mem_req, ram_we}), 0);
        check("R7 reset pc", 64'(pc), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R5 idle stays not running", 64'(run), 0);

        for (int t = 0; t < 3; t++) launch(VEC[t]);

        // R8: writes while running, each selector
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); io_we = 1; io_sel = 2'(s); io_wdata = 32'h10 * (s + 1) + 32'h5;
        end
        @(negedge clk); io_we = 0;
        @(negedge clk);
        check("R8 dir write", 64'(dir_q), 64'h15);
        check("R8 ctra write", 64'(ctra_q), 64'h25);
        check("R8 ctrb write", 64'(ctrb_q), 64'h35);
        check("R8 vcfg write", 64'(vcfg_q), 64'h45);

        // R6: relaunch from run is accepted
        start_req = 1; start_addr = 16'h0400; start_param = 32'h4444_0004;
        @(negedge clk); start_req = 0;
        #3;
        check("R6 relaunch from run accepted", 64'({run, mem_req}), 64'b01);
        @(negedge clk); io_we = 1; io_sel = 2'd3; io_wdata = 32'h77;
        @(negedge clk); io_we = 0;
        @(negedge clk);
        check("R8 io write ignored during relaunch", 64'(vcfg_q), 64'h45);

        // R7: asynchronous clear between edges
        #2; rst_n = 0; #1;
        check("R7 async io clear", 64'(|{dir_q, ctra_q, ctrb_q, vcfg_q}), 0);
        check("R7 async state clear", 64'({run, mem_req, ram_we}), 0);
        check("R7 pc cleared", 64'(pc), 0);
        @(negedge clk);
        check("R8 io regs stay clear while inactive", 64'(|{dir_q, vcfg_q}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule